// File: doc/BRIEF.md
# Control/Bulk Service-Ratio Arbiter

This block decides, each time the non-periodic list processor asks, whether the next descriptor to service comes from the control list or from the bulk list. A 2-bit ratio setting selects how many non-empty control descriptors may be serviced in a row before one bulk descriptor gets a turn. The block keeps an internal count of the non-empty control descriptors serviced since the last bulk descriptor. That count is not touched by frame boundaries, so the ratio holds across frames.

The list processor raises `req` for one cycle at each decision point. One cycle later the block answers with `dec_vld` and the choice. The processor reports completed work with `ctl_done` (a control descriptor was processed and it was non-empty) and `blk_done` (a bulk descriptor was serviced). When one list is empty, the other list is chosen. When both lists are empty, the block answers "none". The count is 0 after reset. Software must load the ratio again after a reset; the input is read as 00 (1:1) until it does.

Top module: `ctl_bulk_arb`

## Requirements
- R1: While reset is held and right after it, `dec_vld`, `dec_blk` and `dec_none` are 0 and the count is 0. The first decision with both lists non-empty is therefore control.
- R2: `dec_vld` is high in exactly the cycles that follow a cycle with `req` high. When `dec_vld` is low, `dec_blk` and `dec_none` are 0.
- R3: With both lists non-empty, the decision is bulk (`dec_blk`=1) when count > `ratio`, and control (`dec_blk`=0) otherwise. The `ratio` encoding is 00=1:1, 01=2:1, 10=3:1, 11=4:1 (control:bulk).
- R4: Only a `ctl_done` pulse raises the count. `frame_tick` leaves the count unchanged.
- R5: A `blk_done` pulse clears the count to 0. It wins over a `ctl_done` in the same cycle.
- R6: Control list empty and bulk list non-empty gives bulk. Bulk list empty and control list non-empty gives control, whatever the count. Both lists empty gives `dec_none`=1 with `dec_blk`=0.
- R7: The count saturates at 4. Further `ctl_done` pulses keep it at 4.
- R8: A change of `ratio` applies at the next decision, and the count is kept.
- R9: A decision uses the count as it stood before any `ctl_done` or `blk_done` in the same cycle as `req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio | input | 2 | Control:bulk service ratio code |
| ctl_empty | input | 1 | Control list has no descriptor |
| blk_empty | input | 1 | Bulk list has no descriptor |
| req | input | 1 | Decision request pulse |
| ctl_done | input | 1 | Non-empty control descriptor processed |
| blk_done | input | 1 | Bulk descriptor serviced |
| frame_tick | input | 1 | Frame boundary strobe |
| dec_vld | output | 1 | Decision valid |
| dec_blk | output | 1 | 1 = service bulk, 0 = service control |
| dec_none | output | 1 | Both lists empty, nothing to service |

## Verification
Each decision appears exactly one clock after its `req` cycle. A `ctl_done` or `blk_done` pulse changes the count at that same edge, so it first affects a decision requested in the next cycle. The bench drives inputs 5 ns after a rising edge. It computes the expected decision from its own count model before applying that cycle's count updates, and it compares the outputs 5 ns after the following rising edge. Ratio changes, frame strobes and simultaneous pulses are all checked through later decisions at the ports.

// File: rtl/ctl_bulk_arb.sv
module ctl_bulk_arb #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ctl_empty,
  input  logic               blk_empty,
  input  logic               req,
  input  logic               ctl_done,
  input  logic               blk_done,
  input  logic               frame_tick,
  output logic               dec_vld,
  output logic               dec_blk,
  output logic               dec_none
);
  localparam int CNT_MAX = 1 << RATIO_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic             ratio_met, pick_none, pick_blk;

  assign ratio_met = cnt > CNT_W'(ratio);
  assign pick_none = ctl_empty & blk_empty;
  assign pick_blk  = ~pick_none & (ctl_empty | (~blk_empty & ratio_met));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (blk_done)
      cnt <= '0;
    else if (ctl_done && cnt != CNT_W'(CNT_MAX))
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      dec_blk  <= 1'b0;
      dec_none <= 1'b0;
    end else begin
      dec_vld  <= req;
      dec_blk  <= req & pick_blk;
      dec_none <= req & pick_none;
    end
  end

  logic unused_tick;
  assign unused_tick = frame_tick;
endmodule

module ctl_bulk_arb_chk #(
  parameter int CNT_W = 3,
  parameter int CNT_MAX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             ctl_empty,
  input logic             blk_empty,
  input logic             ctl_done,
  input logic             blk_done,
  input logic             dec_vld,
  input logic             dec_blk,
  input logic             dec_none,
  input logic [CNT_W-1:0] cnt
);
  a_r2_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> dec_vld);
  a_r2_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !dec_vld);
  a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> (!dec_blk && !dec_none));
  a_r5_bulk_clears: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> cnt == '0);
  a_r6_ctl_empty_bulk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ctl_empty && !blk_empty) |=> (dec_blk && !dec_none));
  a_r6_blk_empty_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl_empty && blk_empty) |=> (!dec_blk && !dec_none));
  a_r6_both_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ctl_empty && blk_empty) |=> (dec_none && !dec_blk));
  a_r4_only_ctl_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_done && !blk_done) |=> $stable(cnt));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

bind ctl_bulk_arb ctl_bulk_arb_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ctl_empty(ctl_empty),
  .blk_empty(blk_empty), .ctl_done(ctl_done), .blk_done(blk_done),
  .dec_vld(dec_vld), .dec_blk(dec_blk), .dec_none(dec_none), .cnt(cnt)
);

// File: tb/sim_ctl_bulk_arb.sv
`timescale 1ns/1ps
module sim_ctl_bulk_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ratio = 2'b00;
  logic ctl_empty = 1'b0, blk_empty = 1'b0, req = 1'b0;
  logic ctl_done = 1'b0, blk_done = 1'b0, frame_tick = 1'b0;
  logic dec_vld, dec_blk, dec_none;

  int tests = 0, fails = 0, mcnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ctl_bulk_arb u0 (
    .clk(clk), .rst_n(rst_n), .ratio(ratio), .ctl_empty(ctl_empty),
    .blk_empty(blk_empty), .req(req), .ctl_done(ctl_done),
    .blk_done(blk_done), .frame_tick(frame_tick),
    .dec_vld(dec_vld), .dec_blk(dec_blk), .dec_none(dec_none)
  );

  function automatic logic [1:0] exp_dec(int c, logic [1:0] r, logic ce, logic be);
    if (ce && be) return 2'b10;
    if (ce) return 2'b01;
    if (be) return 2'b00;
    return (c > int'(r)) ? 2'b01 : 2'b00;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {vld,none,blk} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic rq, logic ce, logic be, logic [1:0] r,
                      logic cd, logic bd, logic ft, string tag);
    logic [1:0] e;
    req = rq; ctl_empty = ce; blk_empty = be; ratio = r;
    ctl_done = cd; blk_done = bd; frame_tick = ft;
    e = exp_dec(mcnt, r, ce, be);
    if (bd) mcnt = 0;
    else if (cd && mcnt < 4) mcnt++;
    @(posedge clk); #5;
    req = 0; ctl_done = 0; blk_done = 0; frame_tick = 0;
    if (rq) check(tag, {dec_vld, dec_none, dec_blk}, {1'b1, e});
    else    check("R2", {dec_vld, dec_none, dec_blk}, 3'b000);
  endtask

  // one serviced control descriptor, then a decision
  task automatic serve_ratio(logic [1:0] r);
    mcnt = mcnt;
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, r, 0, 0, 0, "R3");
      if (dec_blk) step(0, 0, 0, r, 0, 1, 0, "R5");
      else         step(0, 0, 0, r, 1, 0, 0, "R4");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #5 check("R1", {dec_vld, dec_none, dec_blk}, 3'b000);
    rst_n = 1'b1;
    @(posedge clk); #5;
    step(1, 0, 0, 2'b11, 0, 0, 0, "R1");

    for (int r = 0; r < 4; r++) begin
      step(0, 0, 0, 2'(r), 0, 1, 0, "R5");
      serve_ratio(2'(r));
    end

    // frame boundaries keep the count
    step(0, 0, 0, 2'b01, 0, 1, 0, "R5");
    step(0, 0, 0, 2'b01, 1, 0, 0, "R4");
    step(0, 0, 0, 2'b01, 0, 0, 1, "R4");
    step(0, 0, 0, 2'b01, 1, 0, 1, "R4");
    step(1, 0, 0, 2'b01, 0, 0, 0, "R4");

    // saturation and ratio change keeping count
    for (int i = 0; i < 7; i++) step(0, 0, 0, 2'b11, 1, 0, 0, "R7");
    step(1, 0, 0, 2'b11, 0, 0, 0, "R7");
    step(1, 0, 0, 2'b00, 0, 0, 0, "R8");
    step(0, 0, 0, 2'b11, 0, 1, 0, "R5");
    step(1, 0, 0, 2'b11, 0, 0, 0, "R7");

    // simultaneous done pulses and same-cycle request
    step(0, 0, 0, 2'b00, 1, 0, 0, "R4");
    step(1, 0, 0, 2'b00, 1, 1, 0, "R9");
    step(1, 0, 0, 2'b00, 0, 0, 0, "R5");
    step(1, 0, 0, 2'b00, 1, 0, 0, "R9");
    step(1, 0, 0, 2'b00, 0, 0, 0, "R9");

    // empty lists
    step(1, 1, 0, 2'b11, 0, 0, 0, "R6");
    step(1, 0, 1, 2'b00, 0, 0, 0, "R6");
    step(1, 1, 1, 2'b10, 0, 0, 0, "R6");

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 15);
      step($urandom_range(0, 3) != 0, k == 0 || k == 1, k == 2 || k == 1,
           2'($urandom_range(0, 3)), $urandom_range(0, 2) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0, "R3");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule